// File: doc/BRIEF.md
# DMA Block-Chaining Mode Controller

This block sequences the blocks of one DMA channel. It holds the current address and the remaining byte count. It also holds a second address/count pair that is copied into the current pair at the end of a block. The transfer engine reports each byte it moves on a one-cycle `xfer_done` strobe. On each strobe the controller steps the address and decrements the count.

When the last byte of a block completes, one of three things happens:
- **Single-buffer:** the channel stops and reports an overrun.
- **Double-buffer:** if software has armed the next block with a valid flag, the channel switches to it.
- **Auto-initialize:** the channel reloads the same block from the base pair.

The `chan_active` output gates request servicing in the transfer engine. A one-cycle `tc_irq` pulse signals the end of a block when it is enabled.

Software reaches every register through a single-cycle write port and a combinational read port. Both ports are selected by `reg_sel`.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset every readable register (selects 0 to 7) reads 0, and `chan_active` and `tc_irq` are low.
- R2: Writing control (select 5) with bit0 = 1 while the enable bit is 0 sets the active flag. The active flag is visible on `chan_active` and in status bit2. Writing bit0 = 0 clears the active flag. While the channel is inactive, `xfer_done` changes nothing.
- R3: Each `xfer_done` accepted while active decrements the current count (select 1) by one. It also changes the current address (select 0) according to mode (select 4):
  - bit2 = 1 holds the address (hold wins over bit1);
  - otherwise bit1 = 1 decrements the address modulo 2^ADDR_W;
  - otherwise the address increments.
- R4: The accepted `xfer_done` with a count of 1 (or 0) ends the block. If auto-init (mode bit0) and next-valid (control bit1) are both 0, the following all happen:
  - the count reads 0;
  - status bit0 (terminal count) and status bit1 (overrun) become 1;
  - the active flag clears.
- R5: In the cycle after an end of block, `tc_irq` is high for exactly one cycle if control bit2 is 1. If control bit2 is 0, `tc_irq` stays low.
- R6: At the end of a block with auto-init 0 and next-valid 1, the following all happen:
  - the next address (select 2) and next count (select 3) are loaded into the current address and count;
  - next-valid clears;
  - terminal count sets;
  - the channel stays active.
- R7: At the end of a block with auto-init 0 and next-valid 0 (the double-buffer case where the next block was not armed in time), overrun sets and the active flag clears.
- R8: When an overrun occurs and status bit3 (overrun-stop enable) is 1, control bit0 is forced to 0. When status bit3 is 0, control bit0 keeps its value.
- R9: At the end of a block with auto-init 1, the base pair (selects 2 and 3) is loaded into the current counters and terminal count sets. The channel stays active and next-valid is left unchanged, so the block repeats.
- R10: While control bit0 is 1, writes to selects 0, 1, 4 and 6 have no effect.
- R11: With the channel disabled, writing 1 to status bit0 or bit1 clears that bit and leaves the other bit unchanged. A status write also loads status bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data of the selected register (combinational) |
| xfer_done | input | 1 | One byte moved by the transfer engine |
| chan_active | output | 1 | Channel may service transfer requests |
| tc_irq | output | 1 | One-cycle terminal-count interrupt pulse |

## Verification
The bench builds the block with ADDR_W = 12 and CNT_W = 6. With a 12-bit address, the decrement mode wraps from 0 to 0xFFF in a single directed step. The 6-bit count keeps each block short. Random counts of 0 to 7 therefore bring many end-of-block events within a few hundred operations, covering chaining, auto-reload, overrun-stop and write-lock in mixed orders.

// File: rtl/dma_chain_pkg.sv
// Package: shared register selects and field layouts for the block-chaining
// DMA controller. Assumes a 3-bit register select.
package dma_chain_pkg;

    typedef enum logic [2:0] {
        SEL_CUR_ADDR = 3'd0,
        SEL_CUR_CNT  = 3'd1,
        SEL_NXT_ADDR = 3'd2,
        SEL_NXT_CNT  = 3'd3,
        SEL_MODE     = 3'd4,
        SEL_CTRL     = 3'd5,
        SEL_STAT     = 3'd6,
        SEL_UNUSED   = 3'd7
    } reg_sel_e;

    // Mode register: bit2 hold address, bit1 decrement address, bit0 auto-init
    typedef struct packed {
        logic hold;
        logic dec;
        logic autoinit;
    } mode_t;

    // Control register: bit2 irq enable, bit1 next block valid, bit0 enable
    typedef struct packed {
        logic irq_en;
        logic nxt_valid;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/dma_chain_counters.sv
// Current address and count counters of one DMA channel.
// Loads from software, steps per accepted byte, or reloads from the
// next/base pair at a chained end of block.
// Assumes software loads and steps never coincide (loads are only allowed
// while the channel is disabled, steps only while active).
module dma_chain_counters
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic              step,
    input  logic              reload,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  base_cnt,
    input  mode_t             mode,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              last
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    logic [ADDR_W-1:0] addr_nxt;

    // Final byte of a block: count of one (or an empty count).
    assign last = (cur_cnt <= CNT_ONE);

    // Address step selected by mode: hold, down, or up.
    always_comb begin
        if (mode.hold)     addr_nxt = cur_addr;
        else if (mode.dec) addr_nxt = cur_addr - ADDR_ONE;
        else               addr_nxt = cur_addr + ADDR_ONE;
    end

    // Current address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_addr <= '0;
        else if (ld_addr) cur_addr <= ld_data;
        else if (step)    cur_addr <= reload ? base_addr : addr_nxt;
    end

    // Current count register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_cnt <= '0;
        else if (ld_cnt) cur_cnt <= ld_data[CNT_W-1:0];
        else if (step)   cur_cnt <= reload ? base_cnt : (last ? '0 : cur_cnt - CNT_ONE);
    end

    assert_step_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reload && !last) |=> cur_cnt == $past(cur_cnt) - CNT_ONE);

    assert_reload_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cur_cnt == $past(base_cnt) && cur_addr == $past(base_addr)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_cnt && !ld_addr) |=> ($stable(cur_cnt) && $stable(cur_addr)));

endmodule

// File: rtl/dma_chain_seq.sv
// End-of-block sequencer of one DMA channel.
// Holds the control, mode and status bits, decides between stop, chain and
// auto-reload at the end of a block, and raises the terminal-count pulse.
// Assumes register writes and transfer strobes arrive in separate cycles;
// hardware updates win over a coincident write.
module dma_chain_seq
    import dma_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       wr_mode,
    input  logic       wr_stat,
    input  logic [3:0] wdata,
    input  logic       xfer_done,
    input  logic       last,
    output logic       step,
    output logic       reload,
    output ctrl_t      ctrl,
    output mode_t      mode,
    output logic       tc,
    output logic       ovr,
    output logic       active,
    output logic       ovr_stop_en,
    output logic       tc_irq
);

    logic eob;
    logic overrun;

    assign step    = xfer_done & active;
    assign eob     = step & last;
    assign reload  = eob & (mode.autoinit | ctrl.nxt_valid);
    assign overrun = eob & ~reload;

    // Control bits: software writes, valid consumed on chain, enable forced off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en        <= wdata[0];
                ctrl.nxt_valid <= wdata[1];
                ctrl.irq_en    <= wdata[2];
            end
            if (reload && !mode.autoinit) ctrl.nxt_valid <= 1'b0;
            if (overrun && ovr_stop_en)   ctrl.en <= 1'b0;
        end
    end

    // Active flag: set on enable edge, cleared by disable or overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)        active <= 1'b0;
        else if (overrun)  active <= 1'b0;
        else if (wr_ctrl) begin
            if (!wdata[0])     active <= 1'b0;
            else if (!ctrl.en) active <= 1'b1;
        end
    end

    // Mode bits: writable only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                    mode <= '0;
        else if (wr_mode && !ctrl.en)  mode <= wdata[2:0];
    end

    // Status bits: sticky events cleared by write-one while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc          <= 1'b0;
            ovr         <= 1'b0;
            ovr_stop_en <= 1'b0;
        end else begin
            if (eob)                                  tc <= 1'b1;
            else if (wr_stat && !ctrl.en && wdata[0]) tc <= 1'b0;
            if (overrun)                              ovr <= 1'b1;
            else if (wr_stat && !ctrl.en && wdata[1]) ovr <= 1'b0;
            if (wr_stat && !ctrl.en)                  ovr_stop_en <= wdata[3];
        end
    end

    // Terminal-count interrupt pulse, one cycle after the end of block.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_irq <= 1'b0;
        else        tc_irq <= eob & ctrl.irq_en;
    end

    assert_active_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ctrl.en);

    assert_overrun_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> (!active && ovr && tc));

    assert_irq_with_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |-> tc);

    assert_chain_consumes_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eob && !mode.autoinit && ctrl.nxt_valid) |=> (!ctrl.nxt_valid && active));

    assert_force_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && ovr_stop_en) |=> !ctrl.en);

    assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.en |=> $stable(mode));

endmodule

// File: rtl/dma_chain_ctrl.sv
// Top of the block-chaining DMA controller for one channel.
// Decodes the register port, holds the next/base address and count pair,
// and joins the counters with the end-of-block sequencer.
// Assumes CNT_W <= ADDR_W and ADDR_W >= 4.
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              xfer_done,
    output logic              chan_active,
    output logic              tc_irq
);

    reg_sel_e          sel;
    ctrl_t             ctrl;
    mode_t             mode;
    logic              step, reload, last;
    logic              tc, ovr, active, ovr_stop_en;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [CNT_W-1:0]  cur_cnt, nxt_cnt;
    logic              ld_addr, ld_cnt;

    assign sel     = reg_sel_e'(reg_sel);
    assign ld_addr = reg_wr && sel == SEL_CUR_ADDR && !ctrl.en;
    assign ld_cnt  = reg_wr && sel == SEL_CUR_CNT  && !ctrl.en;

    // Next/base address and count pair, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_addr <= '0;
            nxt_cnt  <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_NXT_ADDR) nxt_addr <= reg_wdata;
            if (sel == SEL_NXT_CNT)  nxt_cnt  <= reg_wdata[CNT_W-1:0];
        end
    end

    dma_chain_counters #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .ld_data   (reg_wdata),
        .step      (step),
        .reload    (reload),
        .base_addr (nxt_addr),
        .base_cnt  (nxt_cnt),
        .mode      (mode),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .last      (last)
    );

    dma_chain_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (reg_wr && sel == SEL_CTRL),
        .wr_mode     (reg_wr && sel == SEL_MODE),
        .wr_stat     (reg_wr && sel == SEL_STAT),
        .wdata       (reg_wdata[3:0]),
        .xfer_done   (xfer_done),
        .last        (last),
        .step        (step),
        .reload      (reload),
        .ctrl        (ctrl),
        .mode        (mode),
        .tc          (tc),
        .ovr         (ovr),
        .active      (active),
        .ovr_stop_en (ovr_stop_en),
        .tc_irq      (tc_irq)
    );

    assign chan_active = active;

    // Read mux of the register port.
    always_comb begin
        case (sel)
            SEL_CUR_ADDR: reg_rdata = cur_addr;
            SEL_CUR_CNT:  reg_rdata = ADDR_W'(cur_cnt);
            SEL_NXT_ADDR: reg_rdata = nxt_addr;
            SEL_NXT_CNT:  reg_rdata = ADDR_W'(nxt_cnt);
            SEL_MODE:     reg_rdata = ADDR_W'(mode);
            SEL_CTRL:     reg_rdata = ADDR_W'(ctrl);
            SEL_STAT:     reg_rdata = ADDR_W'({ovr_stop_en, active, ovr, tc});
            default:      reg_rdata = '0;
        endcase
    end

    assert_addr_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && !step) |=> $stable(cur_addr));

endmodule

// File: tb/dma_chain_ctrl_test.sv
`timescale 1ns/1ps
module dma_chain_ctrl_test;
    localparam int AW = 12;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          xfer_done = 1'b0;
    logic          chan_active;
    logic          tc_irq;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference state kept from the requirements.
    logic [AW-1:0] m_addr, m_base_addr;
    logic [CW-1:0] m_cnt, m_base_cnt;
    logic m_auto, m_dec, m_hold, m_en, m_valid, m_irqen;
    logic m_tc, m_ovr, m_act, m_ostop, m_irq;

    dma_chain_ctrl #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
        .chan_active(chan_active), .tc_irq(tc_irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_addr = '0; m_base_addr = '0; m_cnt = '0; m_base_cnt = '0;
        m_auto = 0; m_dec = 0; m_hold = 0; m_en = 0; m_valid = 0; m_irqen = 0;
        m_tc = 0; m_ovr = 0; m_act = 0; m_ostop = 0; m_irq = 0;
    endtask

    function automatic logic [AW-1:0] exp_reg(input int s);
        case (s)
            0: return m_addr;
            1: return AW'(m_cnt);
            2: return m_base_addr;
            3: return AW'(m_base_cnt);
            4: return AW'({m_hold, m_dec, m_auto});
            5: return AW'({m_irqen, m_valid, m_en});
            6: return AW'({m_ostop, m_act, m_ovr, m_tc});
            default: return '0;
        endcase
    endfunction

    function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
        if (m_hold)     return a;
        else if (m_dec) return a - AW'(1);
        else            return a + AW'(1);
    endfunction

    task automatic model_write(input int s, input logic [AW-1:0] d);
        case (s)
            0: if (!m_en) m_addr = d;
            1: if (!m_en) m_cnt = d[CW-1:0];
            2: m_base_addr = d;
            3: m_base_cnt = d[CW-1:0];
            4: if (!m_en) begin m_auto = d[0]; m_dec = d[1]; m_hold = d[2]; end
            5: begin
                if (!d[0]) m_act = 0;
                else if (!m_en) m_act = 1;
                m_en = d[0]; m_valid = d[1]; m_irqen = d[2];
            end
            6: if (!m_en) begin
                if (d[0]) m_tc = 0;
                if (d[1]) m_ovr = 0;
                m_ostop = d[3];
            end
            default: ;
        endcase
    endtask

    task automatic model_xfer();
        m_irq = 0;
        if (m_act) begin
            if (m_cnt <= 1) begin
                m_tc  = 1;
                m_irq = m_irqen;
                if (m_auto || m_valid) begin
                    m_addr = m_base_addr; m_cnt = m_base_cnt;
                    if (!m_auto) m_valid = 0;
                end else begin
                    m_addr = step_addr(m_addr); m_cnt = '0;
                    m_ovr = 1; m_act = 0;
                    if (m_ostop) m_en = 0;
                end
            end else begin
                m_addr = step_addr(m_addr);
                m_cnt  = m_cnt - CW'(1);
            end
        end
    endtask

    task automatic do_write(input int s, input logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = 3'(s); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        model_write(s, d);
    endtask

    task automatic do_xfer();
        @(negedge clk);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
        model_xfer();
        check("R5", "tc_irq pulse", 32'(tc_irq), 32'(m_irq));
        @(negedge clk);
        check("R5", "tc_irq one cycle", 32'(tc_irq), 32'd0);
    endtask

    task automatic check_all(input string req);
        for (int s = 0; s < 8; s++) begin
            reg_sel = 3'(s);
            #0.1;
            check(req, $sformatf("reg sel %0d", s), 32'(reg_rdata), 32'(exp_reg(s)));
        end
        check(req, "chan_active", 32'(chan_active), 32'(m_act));
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_all("R1");
        check("R1", "tc_irq", 32'(tc_irq), 32'd0);

        // R2: inactive channel ignores transfers
        do_write(0, 12'h100);
        do_write(1, 12'd3);
        do_xfer();
        check_all("R2");
        do_write(5, 12'b101);
        check_all("R2");

        // R3: increment
        do_xfer();
        do_xfer();
        check_all("R3");
        // R4 single-buffer end, R5 pulse
        do_xfer();
        check_all("R4");
        check("R8", "enable kept without stop", 32'(exp_reg(5) & 1), 32'd1);
        check_all("R8");

        // R10: locked writes while enabled
        do_write(0, 12'h555);
        do_write(1, 12'd9);
        do_write(4, 12'b011);
        do_write(6, 12'b1011);
        check_all("R10");

        // R11: write-one-to-clear, bit by bit
        do_write(5, 12'b000);
        check_all("R2");
        do_write(6, 12'b0001);
        check_all("R11");
        do_write(6, 12'b0010);
        check_all("R11");

        // R3: decrement wraps, then hold
        do_write(0, 12'h000);
        do_write(1, 12'd5);
        do_write(4, 12'b010);
        do_write(5, 12'b001);
        do_xfer();
        check_all("R3");
        do_write(5, 12'b000);
        do_write(4, 12'b110);
        do_write(5, 12'b001);
        do_xfer();
        check_all("R3");

        // R6 double-buffer chain, R7/R8 unarmed overrun with stop enable
        do_write(5, 12'b000);
        do_write(4, 12'b000);
        do_write(6, 12'b1011);
        do_write(0, 12'h200);
        do_write(1, 12'd2);
        do_write(2, 12'h300);
        do_write(3, 12'd4);
        do_write(5, 12'b111);
        do_xfer();
        do_xfer();
        check_all("R6");
        for (int i = 0; i < 4; i++) do_xfer();
        check_all("R7");
        check_all("R8");

        // R9 auto-init repeats, valid untouched, irq disabled (R5)
        do_write(6, 12'b0011);
        do_write(4, 12'b001);
        do_write(0, 12'h050);
        do_write(1, 12'd2);
        do_write(2, 12'h080);
        do_write(3, 12'd3);
        do_write(5, 12'b011);
        do_xfer();
        do_xfer();
        check_all("R9");
        for (int i = 0; i < 3; i++) do_xfer();
        check_all("R9");

        // Random mix checked against the reference state
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 6) begin
                do_xfer();
            end else begin
                int s;
                logic [AW-1:0] d;
                s = $urandom_range(0, 7);
                d = AW'($urandom);
                if (s == 1 || s == 3) d = AW'($urandom_range(0, 7));
                do_write(s, d);
            end
            check_all("R3-rand");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule